// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the combinational integer datapath of a RISC execute stage. Each cycle it takes a 4-bit operation code, a set-flags request, a first operand A and a second operand B that has already been through the shifter. It also takes the shifter's carry-out and the current N, Z, C and V condition flags. It returns the result word, a write-enable for the destination register, and the flag values to be written back.

The block covers add, subtract and reverse subtract, each with and without a carry-in. It also covers four bitwise operations, two moves and four compares. Compares change the flags and never write a result. On subtraction the carry flag reads as "no borrow". Condition evaluation, multiply and the register file are outside the block. The width is the parameter `WIDTH`, which defaults to 32.

Top module: `alu_dp`

## Requirements
- R1: Code 4 gives A+B and code 5 gives A+B+C, where C is the carry flag input. Results are taken modulo 2^WIDTH.
- R2: Code 2 gives A-B and code 6 gives A-B-(1-C). Code 3 gives B-A and code 7 gives B-A-(1-C).
- R3: When an arithmetic operation updates the flags, C is the unsigned carry-out of an addition. For a subtraction, C is 1 when no borrow occurred and 0 when one did.
- R4: When flags update, N is bit WIDTH-1 of the result and Z is 1 exactly when the result is zero. For arithmetic operations, V is 1 exactly when the signed result overflows.
- R5: The bitwise codes are 0 (A AND B), 1 (A XOR B), 12 (A OR B) and 14 (A AND NOT B).
- R6: Code 13 outputs B and code 15 outputs NOT B.
- R7: When a bitwise, move or bit-test operation updates the flags, C takes `sh_carry_i` and V keeps its input value.
- R8: Codes 8 to 11 are compares. Code 8 computes A AND B, code 9 A XOR B, code 10 A-B and code 11 A+B. A compare drives `we_o` to 0 and updates the flags whether or not `set_i` is 1.
- R9: Every non-compare code drives `we_o` to 1. When `set_i` is 0, a non-compare code passes `flags_i` unchanged to `flags_o`.
- R10: A flag-setting move whose output is zero gives Z=1, N=0 and an unchanged V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| set_i | input | 1 | Request that the flags be updated |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand, after the shifter |
| sh_carry_i | input | 1 | Carry-out of the shifter |
| flags_i | input | 4 | Current flags, bit 3 N, bit 2 Z, bit 1 C, bit 0 V |
| res_o | output | WIDTH | Result word |
| we_o | output | 1 | Result write-enable |
| flags_o | output | 4 | Next flags, same bit order as flags_i |

## Verification
The hardest cases to reach are the carry-in forms of reverse subtraction at the signed and unsigned wrap points. There, a single incoming carry decides both the borrow and the overflow, and random words rarely land on them. The bench builds a 4-bit copy of the block and sweeps every code, every operand pair and both values of the set request, the shifter carry and the C and V inputs. This reaches every borrow and overflow edge. A 32-bit copy then checks a few full-width wrap cases against arithmetic done in the bench.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_sel_e;

  typedef enum logic [2:0] {
    LG_AND = 3'd0,
    LG_EOR = 3'd1,
    LG_ORR = 3'd2,
    LG_BIC = 3'd3,
    LG_MOV = 3'd4,
    LG_MVN = 3'd5
  } lg_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic     arith;
    logic     swap;
    logic     inv;
    cin_sel_e cin;
    lg_sel_e  lg;
    logic     cmp;
  } ctrl_t;

endpackage

// File: rtl/alu_dp_dec.sv
module alu_dp_dec
  import alu_dp_pkg::*;
(
  input  logic [3:0] op_i,
  output ctrl_t      ctrl_o
);

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  always_comb begin
    ctrl_o       = '0;
    ctrl_o.cin   = CIN_ZERO;
    ctrl_o.lg    = LG_AND;
    unique case (op)
      OP_AND: ctrl_o.lg = LG_AND;
      OP_EOR: ctrl_o.lg = LG_EOR;
      OP_ORR: ctrl_o.lg = LG_ORR;
      OP_BIC: ctrl_o.lg = LG_BIC;
      OP_MOV: ctrl_o.lg = LG_MOV;
      OP_MVN: ctrl_o.lg = LG_MVN;
      OP_TST: begin ctrl_o.lg = LG_AND; ctrl_o.cmp = 1'b1; end
      OP_TEQ: begin ctrl_o.lg = LG_EOR; ctrl_o.cmp = 1'b1; end
      OP_ADD: begin ctrl_o.arith = 1'b1; end
      OP_ADC: begin ctrl_o.arith = 1'b1; ctrl_o.cin = CIN_FLAG; end
      OP_CMN: begin ctrl_o.arith = 1'b1; ctrl_o.cmp = 1'b1; end
      // subtract is x + ~y + 1; carry-in form uses C as "no borrow"
      OP_SUB: begin ctrl_o.arith = 1'b1; ctrl_o.inv = 1'b1; ctrl_o.cin = CIN_ONE; end
      OP_SBC: begin ctrl_o.arith = 1'b1; ctrl_o.inv = 1'b1; ctrl_o.cin = CIN_FLAG; end
      OP_CMP: begin ctrl_o.arith = 1'b1; ctrl_o.inv = 1'b1; ctrl_o.cin = CIN_ONE; ctrl_o.cmp = 1'b1; end
      OP_RSB: begin ctrl_o.arith = 1'b1; ctrl_o.inv = 1'b1; ctrl_o.swap = 1'b1; ctrl_o.cin = CIN_ONE; end
      OP_RSC: begin ctrl_o.arith = 1'b1; ctrl_o.inv = 1'b1; ctrl_o.swap = 1'b1; ctrl_o.cin = CIN_FLAG; end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_dp_add.sv
module alu_dp_add #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] full;

  assign full   = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
  assign sum_o  = full[MSB:0];
  assign cout_o = full[WIDTH];
  // same-sign inputs, different-sign sum
  assign ovf_o  = (x_i[MSB] == y_i[MSB]) && (sum_o[MSB] != x_i[MSB]);

endmodule

// File: rtl/alu_dp_logic.sv
module alu_dp_logic
  import alu_dp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  lg_sel_e          sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);

  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_EOR:  res_o = a_i ^ b_i;
      LG_ORR:  res_o = a_i | b_i;
      LG_BIC:  res_o = a_i & ~b_i;
      LG_MOV:  res_o = b_i;
      LG_MVN:  res_o = ~b_i;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_dp_flags.sv
module alu_dp_flags
  import alu_dp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             arith_i,
  input  logic             cmp_i,
  input  logic             set_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             cout_i,
  input  logic             ovf_i,
  input  logic             sh_carry_i,
  input  flags_t           flags_i,
  output flags_t           flags_o
);

  logic upd;
  assign upd = set_i | cmp_i;

  always_comb begin
    flags_o = flags_i;
    if (upd) begin
      flags_o.n = res_i[WIDTH-1];
      flags_o.z = (res_i == '0);
      flags_o.c = arith_i ? cout_i : sh_carry_i;
      flags_o.v = arith_i ? ovf_i : flags_i.v;
    end
  end

endmodule

// File: rtl/alu_dp.sv
module alu_dp
  import alu_dp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic             set_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sh_carry_i,
  input  logic [3:0]       flags_i,
  output logic [WIDTH-1:0] res_o,
  output logic             we_o,
  output logic [3:0]       flags_o
);

  ctrl_t            ctrl;
  flags_t           fl_in;
  flags_t           fl_out;
  logic [WIDTH-1:0] add_x;
  logic [WIDTH-1:0] add_y;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] lg_res;
  logic             cin;
  logic             cout;
  logic             ovf;

  assign fl_in = flags_t'(flags_i);

  alu_dp_dec u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  // reverse forms swap the operands ahead of the inverter
  assign add_x = ctrl.swap ? b_i : a_i;
  assign add_y = ctrl.inv ? ~(ctrl.swap ? a_i : b_i) : (ctrl.swap ? a_i : b_i);

  always_comb begin
    unique case (ctrl.cin)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = fl_in.c;
      default:  cin = 1'b0;
    endcase
  end

  alu_dp_add #(.WIDTH(WIDTH)) u_add (
    .x_i    (add_x),
    .y_i    (add_y),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout),
    .ovf_o  (ovf)
  );

  alu_dp_logic #(.WIDTH(WIDTH)) u_logic (
    .sel_i (ctrl.lg),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (lg_res)
  );

  assign res_o = ctrl.arith ? sum : lg_res;
  assign we_o  = ~ctrl.cmp;

  alu_dp_flags #(.WIDTH(WIDTH)) u_flags (
    .arith_i    (ctrl.arith),
    .cmp_i      (ctrl.cmp),
    .set_i      (set_i),
    .res_i      (res_o),
    .cout_i     (cout),
    .ovf_i      (ovf),
    .sh_carry_i (sh_carry_i),
    .flags_i    (fl_in),
    .flags_o    (fl_out)
  );

  assign flags_o = fl_out;

endmodule

// File: rtl/alu_dp_chk.sv
module alu_dp_chk #(
  parameter int WIDTH = 32
) (
  input logic [3:0]       op_i,
  input logic             set_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             sh_carry_i,
  input logic [3:0]       flags_i,
  input logic [WIDTH-1:0] res_o,
  input logic             we_o,
  input logic [3:0]       flags_o
);

  logic is_cmp;
  logic is_arith;
  logic upd;

  assign is_cmp   = (op_i[3:2] == 2'b10);
  assign is_arith = (op_i[3:2] == 2'b01) || (op_i[3:1] == 3'b001) || (op_i[3:1] == 3'b101);
  assign upd      = set_i | is_cmp;

  always_comb begin
    if (!$isunknown({op_i, set_i, a_i, b_i, sh_carry_i, flags_i})) begin
      AST_CMP_NO_WRITE: assert (we_o == !is_cmp);                                  // R8
      AST_FLAGS_HELD: assert (upd || flags_o == flags_i);                            // R9
      AST_NZ_FROM_RES: assert (!upd || (flags_o[3] == res_o[WIDTH-1] &&
                                        flags_o[2] == (res_o == '0)));               // R4
      AST_LOGIC_CV: assert (!upd || is_arith ||
                            (flags_o[1] == sh_carry_i && flags_o[0] == flags_i[0])); // R7
      AST_MOV_PASS: assert (op_i != 4'hD || res_o == b_i);                           // R6
      AST_BIC_MASK: assert (op_i != 4'hE || res_o == (a_i & ~b_i));                  // R5
    end
  end

endmodule

bind alu_dp alu_dp_chk #(.WIDTH(WIDTH)) u_chk (
  .op_i       (op_i),
  .set_i      (set_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .sh_carry_i (sh_carry_i),
  .flags_i    (flags_i),
  .res_o      (res_o),
  .we_o       (we_o),
  .flags_o    (flags_o)
);

// File: tb/sim_alu_dp.sv
module sim_alu_dp;

  localparam int W0 = 4;
  localparam int W1 = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0]    op0 = '0, fl0 = '0, fo0;
  logic          s0 = 1'b0, shc0 = 1'b0, we0;
  logic [W0-1:0] a0 = '0, b0 = '0, r0;

  logic [3:0]    op1 = '0, fl1 = '0, fo1;
  logic          s1 = 1'b0, shc1 = 1'b0, we1;
  logic [W1-1:0] a1 = '0, b1 = '0, r1;

  alu_dp #(.WIDTH(W0)) u0 (
    .op_i(op0), .set_i(s0), .a_i(a0), .b_i(b0), .sh_carry_i(shc0),
    .flags_i(fl0), .res_o(r0), .we_o(we0), .flags_o(fo0)
  );

  alu_dp #(.WIDTH(W1)) u1 (
    .op_i(op1), .set_i(s1), .a_i(a1), .b_i(b1), .sh_carry_i(shc1),
    .flags_i(fl1), .res_o(r1), .we_o(we1), .flags_o(fo1)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model from the requirements, plain integer arithmetic
  task automatic model(input int w, input int op, input bit s, input longint a,
                       input longint b, input bit shc, input bit [3:0] fl,
                       output longint r, output bit we, output bit [3:0] fo,
                       output bit arith);
    longint m, t, sa, sb, sv, half;
    bit cf, vf, br;
    m = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    sa = (a >= half) ? a - (m + 1) : a;
    sb = (b >= half) ? b - (m + 1) : b;
    br = !fl[1];
    arith = 1'b1; t = 0; cf = 0; sv = 0;
    case (op)
      4, 11: begin t = a + b;        cf = t > m;        sv = sa + sb; end
      5:     begin t = a + b + fl[1]; cf = t > m;       sv = sa + sb + fl[1]; end
      2, 10: begin t = a - b;        cf = a >= b;       sv = sa - sb; end
      6:     begin t = a - b - br;   cf = a >= b + br;  sv = sa - sb - br; end
      3:     begin t = b - a;        cf = b >= a;       sv = sb - sa; end
      7:     begin t = b - a - br;   cf = b >= a + br;  sv = sb - sa - br; end
      default: begin
        arith = 1'b0;
        case (op)
          0, 8:  t = a & b;
          1, 9:  t = a ^ b;
          12:    t = a | b;
          13:    t = b;
          14:    t = a & ~b;
          default: t = ~b;
        endcase
      end
    endcase
    r  = t & m;
    vf = (sv > half - 1) || (sv < -half);
    we = !(op >= 8 && op <= 11);
    fo = fl;
    if (s || !we) begin
      fo[3] = r[w-1];
      fo[2] = (r == 0);
      fo[1] = arith ? cf : shc;
      fo[0] = arith ? vf : fl[0];
    end
  endtask

  function automatic string res_tag(int op);
    if (op == 4 || op == 5) return "R1";
    if (op == 2 || op == 3 || op == 6 || op == 7) return "R2";
    if (op == 13 || op == 15) return "R6";
    return "R5";
  endfunction

  task automatic compare(int w, int op, bit s, longint a, longint b, bit shc, bit [3:0] fl,
                         longint r, bit we, bit [3:0] fo);
    longint er; bit ewe; bit [3:0] efo; bit ar;
    model(w, op, s, a, b, shc, fl, er, ewe, efo, ar);
    if (ewe) chk(res_tag(op), r, er);
    chk(ewe ? "R9 we" : "R8 we", longint'(we), longint'(ewe));
    if (!(s || !ewe)) begin
      chk("R9 flags held", longint'(fo), longint'(efo));
    end else begin
      chk((op == 13 || op == 15) && er == 0 ? "R10 NZ" : "R4 NZ",
          longint'(fo[3:2]), longint'(efo[3:2]));
      chk(ar ? "R3 C" : "R7 C", longint'(fo[1]), longint'(efo[1]));
      chk(ar ? "R4 V" : "R7 V", longint'(fo[0]), longint'(efo[0]));
    end
  endtask

  task automatic run1(int op, bit s, longint a, longint b, bit shc, bit [3:0] fl);
    @(posedge clk);
    op1 = op[3:0]; s1 = s; a1 = a[W1-1:0]; b1 = b[W1-1:0]; shc1 = shc; fl1 = fl;
    @(negedge clk);
    compare(W1, op, s, a, b, shc, fl, longint'(r1), we1, fo1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle inputs: AND of zeros, no flag update
    @(negedge clk);
    chk("R9 idle we", longint'(we0), 1);
    chk("R9 idle flags", longint'(fo0), 0);

    // exhaustive sweep of the 4-bit copy
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int k = 0; k < 16; k++) begin
            @(posedge clk);
            op0 = op[3:0]; a0 = a[3:0]; b0 = b[3:0];
            s0 = k[0]; shc0 = k[1];
            fl0 = {a[0] ^ k[3], b[1], k[2], k[3]};
            @(negedge clk);
            compare(W0, op, s0, a, b, shc0, fl0, longint'(r0), we0, fo0);
          end

    // full-width wrap points
    run1(2, 1, 3, 5, 0, 4'b0000);                          // R3 borrow: C=0
    chk("R3 3-5 C", longint'(fo1[1]), 0);
    run1(2, 1, 5, 3, 0, 4'b0000);                          // R3 no borrow: C=1
    chk("R3 5-3 C", longint'(fo1[1]), 1);
    run1(14, 0, 32'h11111111, 32'h01100101, 0, 4'b0000);   // R5 bit clear
    chk("R5 bic", longint'(r1), 32'h10011010);
    run1(13, 1, 0, 0, 1, 4'b1001);                         // R10 move zero
    chk("R10 flags", longint'(fo1), 4'b0111);
    run1(4, 1, 32'h7fffffff, 1, 0, 4'b0000);               // R4 signed overflow
    chk("R4 V", longint'(fo1[0]), 1);
    run1(5, 1, 32'hffffffff, 0, 0, 4'b0010);               // R1 carry-in wraps to zero
    chk("R1 adc", longint'(r1), 0);
    run1(7, 1, 1, 32'h80000000, 0, 4'b0000);               // R2 reverse with borrow
    chk("R2 rsc", longint'(r1), 32'h7ffffffe);
    run1(10, 0, 7, 7, 0, 4'b1001);                         // R8 compare ignores set_i
    chk("R8 cmp flags", longint'(fo1), 4'b0110);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule